// File: doc/BRIEF.md
# Scroll and video address registers

This block keeps the state a raster display engine uses both as a CPU pointer into video memory and as the background scroll position. That state is a 15-bit current address, a 15-bit staging (temporary) address, a 3-bit fine horizontal offset and a one-bit toggle. The toggle selects which half of a two-write sequence the next scroll or address write fills. The current address is packed into fields: bits 4–0 are coarse column, bits 9–5 are coarse row, bits 11–10 select the nametable, and bits 14–12 are the fine row.

The CPU side updates the staging address through three write targets: control, scroll and address. A completed address pair also loads the staging value into the current address. The render side is driven by strobes from a timing generator, which issues them at the proper dots and scanlines. Two strobes step the current address through the screen, one per tile column and one per line. The other two copy the horizontal or the vertical fields back from the staging address. Memory access and pixel output belong to neighbouring blocks.

Top module: `vaddr_scroll_regs`

## Requirements
- R1: After reset, the current address, the staging address, the fine horizontal offset and the toggle are all zero.
- R2: A write with `wr_sel`=0 (control) puts `wr_data[1:0]` into staging bits 11–10. It leaves the toggle, the fine horizontal offset and the current address unchanged.
- R3: A write with `wr_sel`=1 (scroll) inverts the toggle. When the toggle was 0, `wr_data[7:3]` goes to staging bits 4–0 and `wr_data[2:0]` goes to the fine horizontal offset. When it was 1, `wr_data[7:3]` goes to staging bits 9–5 and `wr_data[2:0]` to staging bits 14–12. The fine offset changes on no other event.
- R4: A write with `wr_sel`=2 (address) inverts the same toggle. When the toggle was 0, `wr_data[5:0]` goes to staging bits 13–8 and staging bit 14 is cleared. When it was 1, `wr_data` goes to staging bits 7–0 and the resulting staging address is copied into the current address.
- R5: `inc_h` steps the coarse column. At 31 the column becomes 0 and bit 10 inverts; otherwise the column adds one.
- R6: `inc_v` steps the fine row. From 7 the fine row becomes 0 and the coarse row steps. From 29 the coarse row becomes 0 and bit 11 inverts. From 31 it becomes 0 and bit 11 is unchanged. Any other value adds one.
- R7: `copy_h` copies staging bits 10 and 4–0 into the current address.
- R8: `copy_v` copies staging bits 14–11 and 9–5 into the current address.
- R9: A write with `wr_sel`=3 changes no state. Later writes see the same toggle, and later copies see the same staging address.
- R10: Within one cycle the strobes act in the order `inc_h`, `inc_v`, `copy_h`, `copy_v`, and copies use the staging value held before that cycle. The load from the second address write overrides all strobes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 scroll, 2 address, 3 none |
| wr_data | input | 8 | CPU write data |
| inc_h | input | 1 | Step coarse column |
| inc_v | input | 1 | Step fine/coarse row |
| copy_h | input | 1 | Copy horizontal fields from staging |
| copy_v | input | 1 | Copy vertical fields from staging |
| vaddr | output | 15 | Current video address |
| fine_x | output | 3 | Fine horizontal offset |

## Verification
The bench builds the block with its defaults: a 3-bit fine row, 5-bit coarse fields and 30 visible tile rows. Wide-open scroll data can then load coarse rows 30 and 31, which the render strobes alone never reach, so the non-toggling wrap from 31 becomes testable. Directed steps hit the column-31 and row-29 wraps and the masking of bit 14 on the first address write. Random mixes of simultaneous writes and strobes exercise the ordering and override rules.

// File: rtl/vaddr_pkg.sv
package vaddr_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_SCROLL = 2'd1,
        SEL_ADDR   = 2'd2,
        SEL_NONE   = 2'd3
    } wr_sel_e;
endpackage

// File: rtl/vaddr_cpu_update.sv
module vaddr_cpu_update
    import vaddr_pkg::*;
#(
    parameter  int FINE_W   = 3,
    parameter  int COARSE_W = 5,
    localparam int DATA_W   = COARSE_W + FINE_W,
    localparam int ADDR_W   = FINE_W + 2 + 2 * COARSE_W
) (
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] t_q,
    input  logic [FINE_W-1:0] fx_q,
    input  logic              w_q,
    output logic [ADDR_W-1:0] t_d,
    output logic [FINE_W-1:0] fx_d,
    output logic              w_d,
    output logic              load_v
);
    localparam int CY_LO = COARSE_W;
    localparam int NT_LO = 2 * COARSE_W;
    localparam int FY_LO = NT_LO + 2;
    localparam int HI_W  = ADDR_W - 1 - DATA_W;

    wr_sel_e sel;
    assign sel = wr_sel_e'(wr_sel);

    always_comb begin
        t_d    = t_q;
        fx_d   = fx_q;
        w_d    = w_q;
        load_v = 1'b0;
        if (wr_en) begin
            unique case (sel)
                SEL_CTRL: begin
                    t_d[NT_LO +: 2] = wr_data[1:0];
                end
                SEL_SCROLL: begin
                    w_d = !w_q;
                    if (!w_q) begin
                        t_d[0 +: COARSE_W] = wr_data[DATA_W-1 -: COARSE_W];
                        fx_d               = wr_data[FINE_W-1:0];
                    end else begin
                        t_d[CY_LO +: COARSE_W] = wr_data[DATA_W-1 -: COARSE_W];
                        t_d[FY_LO +: FINE_W]   = wr_data[FINE_W-1:0];
                    end
                end
                SEL_ADDR: begin
                    w_d = !w_q;
                    if (!w_q) begin
                        t_d[DATA_W +: HI_W] = wr_data[HI_W-1:0];
                        t_d[ADDR_W-1]       = 1'b0;
                    end else begin
                        t_d[DATA_W-1:0] = wr_data;
                        load_v          = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/vaddr_render_step.sv
module vaddr_render_step #(
    parameter  int FINE_W   = 3,
    parameter  int COARSE_W = 5,
    parameter  int ROWS     = 30,
    localparam int ADDR_W   = FINE_W + 2 + 2 * COARSE_W
) (
    input  logic [ADDR_W-1:0] v_in,
    input  logic [ADDR_W-1:0] t_in,
    input  logic              inc_h,
    input  logic              inc_v,
    input  logic              copy_h,
    input  logic              copy_v,
    output logic [ADDR_W-1:0] v_out
);
    localparam int CY_LO = COARSE_W;
    localparam int NT_LO = 2 * COARSE_W;
    localparam int FY_LO = NT_LO + 2;
    localparam logic [COARSE_W-1:0] C_MAX   = {COARSE_W{1'b1}};
    localparam logic [COARSE_W-1:0] CY_LAST = COARSE_W'(ROWS - 1);
    localparam logic [FINE_W-1:0]   FY_MAX  = {FINE_W{1'b1}};

    logic [ADDR_W-1:0]   v;
    logic [COARSE_W-1:0] cy;

    always_comb begin
        v  = v_in;
        cy = '0;
        // column step, crossing into the neighbouring nametable at the edge
        if (inc_h) begin
            if (v[0 +: COARSE_W] == C_MAX) begin
                v[0 +: COARSE_W] = '0;
                v[NT_LO]         = ~v[NT_LO];
            end else begin
                v[0 +: COARSE_W] = v[0 +: COARSE_W] + COARSE_W'(1);
            end
        end
        // line step: fine row first, then coarse row with its two wraps
        if (inc_v) begin
            if (v[FY_LO +: FINE_W] != FY_MAX) begin
                v[FY_LO +: FINE_W] = v[FY_LO +: FINE_W] + FINE_W'(1);
            end else begin
                v[FY_LO +: FINE_W] = '0;
                cy = v[CY_LO +: COARSE_W];
                if (cy == CY_LAST) begin
                    cy           = '0;
                    v[NT_LO + 1] = ~v[NT_LO + 1];
                end else if (cy == C_MAX) begin
                    cy = '0;
                end else begin
                    cy = cy + COARSE_W'(1);
                end
                v[CY_LO +: COARSE_W] = cy;
            end
        end
        if (copy_h) begin
            v[NT_LO]         = t_in[NT_LO];
            v[0 +: COARSE_W] = t_in[0 +: COARSE_W];
        end
        if (copy_v) begin
            v[ADDR_W-1:NT_LO+1]  = t_in[ADDR_W-1:NT_LO+1];
            v[CY_LO +: COARSE_W] = t_in[CY_LO +: COARSE_W];
        end
        v_out = v;
    end
endmodule

// File: rtl/vaddr_scroll_regs.sv
module vaddr_scroll_regs
    import vaddr_pkg::*;
#(
    parameter  int FINE_W   = 3,
    parameter  int COARSE_W = 5,
    parameter  int ROWS     = 30,
    localparam int DATA_W   = COARSE_W + FINE_W,
    localparam int ADDR_W   = FINE_W + 2 + 2 * COARSE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inc_h,
    input  logic              inc_v,
    input  logic              copy_h,
    input  logic              copy_v,
    output logic [ADDR_W-1:0] vaddr,
    output logic [FINE_W-1:0] fine_x
);
    localparam int CY_LO = COARSE_W;
    localparam int NT_LO = 2 * COARSE_W;
    localparam int FY_LO = NT_LO + 2;
    localparam logic [COARSE_W-1:0] CY_LAST = COARSE_W'(ROWS - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] v;
        logic [ADDR_W-1:0] t;
        logic [FINE_W-1:0] fx;
        logic              w;
    } state_t;

    state_t            st_q, st_d;
    logic [ADDR_W-1:0] t_nxt, v_step;
    logic [FINE_W-1:0] fx_nxt;
    logic              w_nxt, load_v;

    vaddr_cpu_update #(.FINE_W(FINE_W), .COARSE_W(COARSE_W)) u_cpu (
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .t_q    (st_q.t),
        .fx_q   (st_q.fx),
        .w_q    (st_q.w),
        .t_d    (t_nxt),
        .fx_d   (fx_nxt),
        .w_d    (w_nxt),
        .load_v (load_v)
    );

    vaddr_render_step #(.FINE_W(FINE_W), .COARSE_W(COARSE_W), .ROWS(ROWS)) u_step (
        .v_in  (st_q.v),
        .t_in  (st_q.t),
        .inc_h (inc_h),
        .inc_v (inc_v),
        .copy_h(copy_h),
        .copy_v(copy_v),
        .v_out (v_step)
    );

    always_comb begin
        st_d.t  = t_nxt;
        st_d.fx = fx_nxt;
        st_d.w  = w_nxt;
        st_d.v  = load_v ? t_nxt : v_step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vaddr  = st_q.v;
    assign fine_x = st_q.fx;

    logic any_strobe, scroll_wr, addr_wr, addr_load, only_h, only_v;
    assign any_strobe = inc_h | inc_v | copy_h | copy_v;
    assign scroll_wr  = wr_en && (wr_sel == SEL_SCROLL);
    assign addr_wr    = wr_en && (wr_sel == SEL_ADDR);
    assign addr_load  = addr_wr && st_q.w;
    assign only_h     = inc_h && !inc_v && !copy_h && !copy_v && !addr_load;
    assign only_v     = inc_v && !inc_h && !copy_h && !copy_v && !addr_load;

    assert_toggle_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scroll_wr || addr_wr) |=> (st_q.w != $past(st_q.w)));

    assert_ctrl_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_CTRL) |=> ($stable(st_q.w) && $stable(st_q.fx)));

    assert_fine_x_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(scroll_wr && !st_q.w) |=> $stable(st_q.fx));

    assert_addr_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> (st_q.v == st_q.t));

    assert_hwrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (only_h && st_q.v[0 +: COARSE_W] == '1) |=>
        (st_q.v[0 +: COARSE_W] == '0 && st_q.v[NT_LO] != $past(st_q.v[NT_LO])));

    assert_vwrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (only_v && st_q.v[FY_LO +: FINE_W] == '1 && st_q.v[CY_LO +: COARSE_W] == CY_LAST) |=>
        (st_q.v[CY_LO +: COARSE_W] == '0 && st_q.v[NT_LO+1] != $past(st_q.v[NT_LO+1])));

    assert_copy_h_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_h && !copy_v && !addr_load) |=>
        (st_q.v[NT_LO] == $past(st_q.t[NT_LO]) &&
         st_q.v[0 +: COARSE_W] == $past(st_q.t[0 +: COARSE_W])));

    assert_copy_v_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (copy_v && !addr_load) |=>
        (st_q.v[ADDR_W-1:NT_LO+1] == $past(st_q.t[ADDR_W-1:NT_LO+1]) &&
         st_q.v[CY_LO +: COARSE_W] == $past(st_q.t[CY_LO +: COARSE_W])));

    assert_ignored_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_NONE && !any_strobe) |=> $stable(st_q));
endmodule

// File: tb/vaddr_scroll_regs_tb.sv
module vaddr_scroll_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        inc_h = 1'b0, inc_v = 1'b0, copy_h = 1'b0, copy_v = 1'b0;
    logic [14:0] vaddr;
    logic [2:0]  fine_x;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [14:0] m_v, m_t;
    logic [2:0]  m_fx;
    bit          m_w;

    always #2 clk = ~clk;

    vaddr_scroll_regs u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .inc_h(inc_h), .inc_v(inc_v), .copy_h(copy_h), .copy_v(copy_v),
        .vaddr(vaddr), .fine_x(fine_x)
    );

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [14:0] ref_inch(input logic [14:0] a);
        logic [14:0] r = a;
        if (a[4:0] == 5'd31) begin r[4:0] = 5'd0; r[10] = ~a[10]; end
        else r[4:0] = a[4:0] + 5'd1;
        return r;
    endfunction

    function automatic logic [14:0] ref_incv(input logic [14:0] a);
        logic [14:0] r = a;
        if (a[14:12] != 3'd7) r[14:12] = a[14:12] + 3'd1;
        else begin
            r[14:12] = 3'd0;
            if (a[9:5] == 5'd29)      begin r[9:5] = 5'd0; r[11] = ~a[11]; end
            else if (a[9:5] == 5'd31) r[9:5] = 5'd0;
            else                      r[9:5] = a[9:5] + 5'd1;
        end
        return r;
    endfunction

    task automatic model_step(input bit en, input logic [1:0] sel, input logic [7:0] d,
                              input bit ih, input bit iv, input bit ch, input bit cv);
        logic [14:0] v = m_v, t = m_t;
        bit load = 1'b0;
        if (ih) v = ref_inch(v);
        if (iv) v = ref_incv(v);
        if (ch) begin v[10] = m_t[10]; v[4:0] = m_t[4:0]; end
        if (cv) begin v[14:11] = m_t[14:11]; v[9:5] = m_t[9:5]; end
        if (en) begin
            case (sel)
                2'd0: t[11:10] = d[1:0];
                2'd1: begin
                    if (!m_w) begin t[4:0] = d[7:3]; m_fx = d[2:0]; end
                    else begin t[9:5] = d[7:3]; t[14:12] = d[2:0]; end
                    m_w = !m_w;
                end
                2'd2: begin
                    if (!m_w) begin t[13:8] = d[5:0]; t[14] = 1'b0; end
                    else begin t[7:0] = d; load = 1'b1; end
                    m_w = !m_w;
                end
                default: ;
            endcase
        end
        m_t = t;
        m_v = load ? t : v;
    endtask

    task automatic step(input bit en, input logic [1:0] sel, input logic [7:0] d,
                        input bit ih, input bit iv, input bit ch, input bit cv, input string tag);
        wr_en = en; wr_sel = sel; wr_data = d;
        inc_h = ih; inc_v = iv; copy_h = ch; copy_v = cv;
        @(posedge clk);
        model_step(en, sel, d, ih, iv, ch, cv);
        @(negedge clk);
        wr_en = 1'b0; inc_h = 1'b0; inc_v = 1'b0; copy_h = 1'b0; copy_v = 1'b0;
        check(tag, {vaddr, fine_x}, {m_v, m_fx});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        m_v = '0; m_t = '0; m_fx = '0; m_w = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", {vaddr, fine_x}, 18'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {vaddr, fine_x}, 18'd0);

        // R2: control sets nametable bits of staging; seen through copies
        step(1, 2'd0, 8'h02, 0, 0, 0, 0, "R2 ctrl write");
        step(0, 2'd0, 8'h00, 0, 0, 0, 1, "R8 copy_v after ctrl");
        check("R2 nametable bit11 copied", {vaddr, fine_x}, {15'h0800, 3'd0});

        // R3: scroll pair
        step(1, 2'd1, 8'hFD, 0, 0, 0, 0, "R3 scroll first");
        check("R3 fine x from first scroll", {15'h0, fine_x}, {15'h0, 3'd5});
        step(1, 2'd1, 8'h5E, 0, 0, 0, 0, "R3 scroll second");
        step(0, 2'd0, 8'h00, 0, 0, 1, 1, "R7 R8 copy both");
        check("R7 R8 copied fields", {vaddr, fine_x}, {15'h697F, 3'd5});

        // R5: column wrap at 31 toggles bit 10
        step(0, 2'd0, 8'h00, 1, 0, 0, 0, "R5 column wrap");
        check("R5 wrap value", {vaddr, 3'd0}, {15'h6D60, 3'd0});
        step(0, 2'd0, 8'h00, 1, 0, 0, 0, "R5 column step");
        check("R5 step value", {vaddr, 3'd0}, {15'h6D61, 3'd0});

        // R4: address pair, bit 14 cleared by first write
        step(1, 2'd2, 8'h7F, 0, 0, 0, 0, "R4 addr first");
        step(1, 2'd2, 8'hA5, 0, 0, 0, 0, "R4 addr second");
        check("R4 loaded address", {vaddr, 3'd0}, {15'h3FA5, 3'd0});

        // R6: row 29 wrap toggles bit 11
        step(1, 2'd2, 8'h33, 0, 0, 0, 0, "R4 addr first b");
        step(1, 2'd2, 8'hA0, 0, 0, 0, 0, "R4 addr second b");
        check("R4 loaded row 29", {vaddr, 3'd0}, {15'h33A0, 3'd0});
        for (int i = 0; i < 4; i++) step(0, 2'd0, 8'h00, 0, 1, 0, 0, "R6 fine row step");
        check("R6 fine row at 7", {vaddr, 3'd0}, {15'h73A0, 3'd0});
        step(0, 2'd0, 8'h00, 0, 1, 0, 0, "R6 row 29 wrap");
        check("R6 row 29 wrap value", {vaddr, 3'd0}, {15'h0800, 3'd0});

        // R6: row 31 wraps without toggling
        step(1, 2'd1, 8'h00, 0, 0, 0, 0, "R3 scroll first c");
        step(1, 2'd1, 8'hFF, 0, 0, 0, 0, "R3 scroll second c");
        step(0, 2'd0, 8'h00, 0, 0, 0, 1, "R8 copy_v row 31");
        check("R8 row 31 loaded", {vaddr, 3'd0}, {15'h73E0, 3'd0});
        step(0, 2'd0, 8'h00, 0, 1, 0, 0, "R6 row 31 wrap");
        check("R6 row 31 wrap value", {vaddr, 3'd0}, {15'h0000, 3'd0});

        // R9: unused target changes nothing
        step(1, 2'd3, 8'hFF, 0, 0, 0, 0, "R9 ignored write");
        step(0, 2'd0, 8'h00, 0, 0, 1, 1, "R9 staging unchanged");
        check("R9 staging via copies", {vaddr, 3'd0}, {15'h73E0, 3'd0});
        step(1, 2'd1, 8'h0B, 0, 0, 0, 0, "R9 toggle unchanged");
        check("R9 first-half scroll still", {15'h0, fine_x}, {15'h0, 3'd3});
        step(1, 2'd1, 8'h00, 0, 0, 0, 0, "R3 realign toggle");

        // R10: load overrides strobes; strobes combine in order
        step(1, 2'd2, 8'h12, 0, 0, 0, 0, "R10 addr first");
        step(1, 2'd2, 8'h34, 1, 1, 1, 1, "R10 load over strobes");
        check("R10 load value", {vaddr, 3'd0}, {15'h1234, 3'd0});
        step(0, 2'd0, 8'h00, 1, 1, 0, 0, "R10 inc_h with inc_v");
        step(1, 2'd1, 8'hF8, 1, 0, 1, 0, "R10 copy uses old staging");

        // randomized mix
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 3000; i++) begin
            bit en = ($urandom % 2) == 0;
            logic [1:0] sel = 2'($urandom % 4);
            logic [7:0] d = 8'($urandom);
            bit ih = ($urandom % 4) == 0;
            bit iv = ($urandom % 4) == 0;
            bit ch = ($urandom % 5) == 0;
            bit cv = ($urandom % 6) == 0;
            step(en, sel, d, ih, iv, ch, cv, "R10 random mix");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule